// File: doc/BRIEF.md
# Sixteen-Bit ALU with Excess Register

This block is the arithmetic core of a small 16-bit processor. Each cycle it receives a 5-bit operation code and two operands, `b` (the destination value) and `a` (the source value). It returns the new value for `b` combinationally. Every arithmetic and shift operation also produces a defined side value, called the excess word. The excess word is not a plain carry flag. It is the upper half of a product, a fractional quotient, the bits shifted out, or a carry or borrow marker.

The excess word lives in a 16-bit register inside the block. That register feeds back into the carry-chained operations and is visible at the `ex_q` port. The compare operations produce no result. They raise `cond_true` when their test holds, and the surrounding pipeline uses this flag to decide whether to skip the next instruction. Operand fetching, memory, cycle timing, index updates and skipping all live outside this block.

Top module: `alu16_ex`

## Requirements
- R1: Opcode 0x01 returns `a` unchanged. Opcodes 0x0a, 0x0b and 0x0c return `b&a`, `b|a` and `b^a`. Any opcode without a defined result (including 0x00, 0x18, 0x19 and the compares) returns `b`.
- R2: Opcode 0x02 returns `(b+a)` mod 2^16 and writes excess 0x0001 on carry out, else 0x0000. Opcode 0x03 returns `(b-a)` mod 2^16 and writes 0xffff when `a > b` unsigned, else 0x0000.
- R3: Opcode 0x04 returns the low 16 bits of the unsigned 32-bit product and writes the high 16 bits as excess. Opcode 0x05 does the same with both operands taken as two's complement.
- R4: Opcode 0x06 returns `b/a` unsigned and writes excess `((b<<16)/a)` mod 2^16. Opcode 0x07 does the same signed, truncating toward zero. For both, a zero `a` gives a result of 0 and writes excess 0.
- R5: Opcode 0x08 returns `b%a` unsigned. Opcode 0x09 returns the signed remainder, which carries the sign of `b` (0xfff9 with 16 gives 0xfff9). A zero `a` gives 0. Neither opcode writes the excess register.
- R6: For shift amounts `a` below 16: opcode 0x0d returns `b>>a` (logical) with excess `((b<<16)>>a)` mod 2^16. Opcode 0x0e returns `b>>>a` (arithmetic) with excess `((b<<16)>>>a)` mod 2^16. Opcode 0x0f returns `b<<a` mod 2^16 with excess `(b<<a)>>16`.
- R7: For shift amounts of 16 or more, opcodes 0x0d and 0x0f return 0 and write excess 0. Opcode 0x0e returns and writes all copies of the sign bit of `b`.
- R8: Opcode 0x1a returns `(b+a+EX)` mod 2^16 and writes excess 1 if the true sum exceeds 0xffff, else 0. Opcode 0x1b returns `(b-a+EX)` mod 2^16 and writes 0xffff if the true value is negative, 0x0001 if it exceeds 0xffff, else 0.
- R9: Opcodes 0x10 through 0x17 raise `cond_true` when, respectively: `(b&a)!=0`, `(b&a)==0`, `b==a`, `b!=a`, `b>a` unsigned, `b>a` signed, `b<a` unsigned, `b<a` signed. `cond_true` is 0 for every other opcode.
- R10: `ex_we` is 1 only when `op_valid` is 1 and the opcode is one of 0x02–0x07, 0x0d–0x0f, 0x1a or 0x1b. `ex_q` loads the new excess at the clock edge when `ex_we` is 1 and holds otherwise. `ex_q` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| op_valid | input | 1 | The operation on the inputs is to commit this cycle |
| opcode | input | 5 | Operation code |
| b_in | input | 16 | Destination operand |
| a_in | input | 16 | Source operand or shift amount |
| result | output | 16 | New destination value (combinational) |
| ex_q | output | 16 | Excess register |
| ex_we | output | 1 | The excess register is written at the next edge |
| cond_true | output | 1 | Compare test holds |

## Verification
The assertions take it as given that `opcode`, `b_in`, `a_in` and `op_valid` are stable through each clock period and that reset deassertion is already synchronized. They also assume that a cycle with `op_valid` low may still carry any opcode, which is why the excess checks are conditioned on `ex_we` and `op_valid` rather than on the opcode alone. The stimulus changes the inputs only on the falling edge, holds each operation for exactly one period, and includes idle cycles with a writing opcode and `op_valid` low, so every assumed input shape actually occurs.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [4:0] {
    OP_SET = 5'h01, OP_ADD = 5'h02, OP_SUB = 5'h03, OP_MUL = 5'h04,
    OP_MLI = 5'h05, OP_DIV = 5'h06, OP_DVI = 5'h07, OP_MOD = 5'h08,
    OP_MDI = 5'h09, OP_AND = 5'h0a, OP_BOR = 5'h0b, OP_XOR = 5'h0c,
    OP_SHR = 5'h0d, OP_ASR = 5'h0e, OP_SHL = 5'h0f, OP_ADX = 5'h1a,
    OP_SBX = 5'h1b
  } alu_op_e;

  // Opcodes that define an excess side value.
  function automatic logic op_writes_ex(input logic [4:0] op);
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_MLI, OP_DIV, OP_DVI,
      OP_SHR, OP_ASR, OP_SHL, OP_ADX, OP_SBX: op_writes_ex = 1'b1;
      default:                                op_writes_ex = 1'b0;
    endcase
  endfunction

  // Compare group occupies 0x10..0x17.
  function automatic logic op_is_cmp(input logic [4:0] op);
    op_is_cmp = (op[4:3] == 2'b10);
  endfunction

endpackage

// File: rtl/alu16_addmul.sv
module alu16_addmul
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  input  logic [W-1:0] ex,
  output logic [W-1:0] res,
  output logic [W-1:0] exn
);
  localparam int W2 = 2 * W;
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ONES = '1;

  logic [W:0]           sum_ab, dif_ab;
  logic [W+1:0]         sum_abx;
  logic signed [W+2:0]  sbx_v;
  logic [W2-1:0]        prod_u;
  logic signed [W2-1:0] prod_s;

  always_comb begin
    sum_ab  = {1'b0, b} + {1'b0, a};
    dif_ab  = {1'b0, b} - {1'b0, a};
    sum_abx = {2'b00, b} + {2'b00, a} + {2'b00, ex};
    sbx_v   = $signed({3'b000, b}) - $signed({3'b000, a}) + $signed({3'b000, ex});
    prod_u  = {{W{1'b0}}, b} * {{W{1'b0}}, a};
    prod_s  = $signed({{W{b[W-1]}}, b}) * $signed({{W{a[W-1]}}, a});

    res = b;
    exn = ex;
    case (op)
      OP_ADD: begin
        res = sum_ab[W-1:0];
        exn = sum_ab[W] ? ONE : '0;
      end
      OP_SUB: begin
        res = dif_ab[W-1:0];
        exn = dif_ab[W] ? ONES : '0;
      end
      OP_MUL: begin
        res = prod_u[W-1:0];
        exn = prod_u[W2-1:W];
      end
      OP_MLI: begin
        res = prod_s[W-1:0];
        exn = prod_s[W2-1:W];
      end
      OP_ADX: begin
        res = sum_abx[W-1:0];
        exn = (|sum_abx[W+1:W]) ? ONE : '0;
      end
      OP_SBX: begin
        res = sbx_v[W-1:0];
        if (sbx_v[W+2])            exn = ONES;
        else if (|sbx_v[W+1:W])    exn = ONE;
        else                       exn = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu16_divmod.sv
module alu16_divmod
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  input  logic [W-1:0] ex,
  output logic [W-1:0] res,
  output logic [W-1:0] exn
);
  localparam int W2 = 2 * W;

  logic                a_zero;
  logic [W-1:0]        dv;
  logic [W2-1:0]       u_frac;
  logic signed [W:0]   s_b, s_a, s_q, s_r;
  logic signed [W2:0]  s_bigb, s_biga, s_frac;

  always_comb begin
    a_zero = (a == '0);
    dv     = a_zero ? W'(1) : a;    // keep every divider defined
    u_frac = {b, {W{1'b0}}} / {{W{1'b0}}, dv};
    s_b    = $signed({b[W-1], b});
    s_a    = $signed({dv[W-1], dv});
    s_q    = s_b / s_a;
    s_r    = s_b % s_a;
    s_bigb = $signed({b[W-1], b, {W{1'b0}}});
    s_biga = $signed({{(W+1){dv[W-1]}}, dv});
    s_frac = s_bigb / s_biga;

    res = b;
    exn = ex;
    case (op)
      OP_DIV: begin
        res = a_zero ? '0 : b / dv;
        exn = a_zero ? '0 : u_frac[W-1:0];
      end
      OP_DVI: begin
        res = a_zero ? '0 : s_q[W-1:0];
        exn = a_zero ? '0 : s_frac[W-1:0];
      end
      OP_MOD: res = a_zero ? '0 : b % dv;
      OP_MDI: res = a_zero ? '0 : s_r[W-1:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  input  logic [W-1:0] ex,
  output logic [W-1:0] res,
  output logic [W-1:0] exn
);
  localparam int W2 = 2 * W;
  localparam int SW = $clog2(W);
  localparam logic [W-1:0] LIMIT = W'(W);

  logic                 wide;
  logic [SW-1:0]        amt;
  logic [W-1:0]         fill;
  logic [W2-1:0]        rfrac, lwide;
  logic signed [W-1:0]  asr_r;
  logic signed [W2-1:0] asr_f;

  always_comb begin
    wide  = (a >= LIMIT);
    amt   = a[SW-1:0];
    fill  = {W{b[W-1]}};
    rfrac = {b, {W{1'b0}}} >> amt;
    lwide = {{W{1'b0}}, b} << amt;
    asr_r = $signed(b) >>> amt;
    asr_f = $signed({b, {W{1'b0}}}) >>> amt;

    res = b;
    exn = ex;
    case (op)
      OP_SHR: begin
        res = wide ? '0 : b >> amt;
        exn = wide ? '0 : rfrac[W-1:0];
      end
      OP_ASR: begin
        res = wide ? fill : asr_r;
        exn = wide ? fill : asr_f[W-1:0];
      end
      OP_SHL: begin
        res = wide ? '0 : lwide[W-1:0];
        exn = wide ? '0 : lwide[W2-1:W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu16_cmp.sv
module alu16_cmp #(
  parameter int W = 16
) (
  input  logic [2:0]   sel,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  output logic         hit
);
  always_comb begin
    case (sel)
      3'd0: hit = |(b & a);
      3'd1: hit = ~|(b & a);
      3'd2: hit = (b == a);
      3'd3: hit = (b != a);
      3'd4: hit = (b > a);
      3'd5: hit = ($signed(b) > $signed(a));
      3'd6: hit = (b < a);
      default: hit = ($signed(b) < $signed(a));
    endcase
  end
endmodule

// File: rtl/alu16_ex.sv
module alu16_ex
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [4:0]   opcode,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] result,
  output logic [W-1:0] ex_q,
  output logic         ex_we,
  output logic         cond_true
);
  logic [W-1:0] am_res, am_ex, dm_res, dm_ex, sh_res, sh_ex;
  logic [W-1:0] ex_d;
  logic         cmp_hit;

  alu16_addmul #(.W(W)) u_addmul (
    .op(opcode), .b(b_in), .a(a_in), .ex(ex_q), .res(am_res), .exn(am_ex));

  alu16_divmod #(.W(W)) u_divmod (
    .op(opcode), .b(b_in), .a(a_in), .ex(ex_q), .res(dm_res), .exn(dm_ex));

  alu16_shift #(.W(W)) u_shift (
    .op(opcode), .b(b_in), .a(a_in), .ex(ex_q), .res(sh_res), .exn(sh_ex));

  alu16_cmp #(.W(W)) u_cmp (
    .sel(opcode[2:0]), .b(b_in), .a(a_in), .hit(cmp_hit));

  // Next-state and output selection.
  always_comb begin
    result = b_in;
    ex_d   = ex_q;
    case (opcode)
      OP_SET: result = a_in;
      OP_AND: result = b_in & a_in;
      OP_BOR: result = b_in | a_in;
      OP_XOR: result = b_in ^ a_in;
      OP_ADD, OP_SUB, OP_MUL, OP_MLI, OP_ADX, OP_SBX: begin
        result = am_res;
        ex_d   = am_ex;
      end
      OP_DIV, OP_DVI, OP_MOD, OP_MDI: begin
        result = dm_res;
        ex_d   = dm_ex;
      end
      OP_SHR, OP_ASR, OP_SHL: begin
        result = sh_res;
        ex_d   = sh_ex;
      end
      default: ;
    endcase
    ex_we     = op_valid && op_writes_ex(opcode);
    cond_true = op_is_cmp(opcode) && cmp_hit;
  end

  // Excess register with explicit clock enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ex_q <= '0;
    else if (ex_we) ex_q <= ex_d;
  end
endmodule

// File: rtl/alu16_ex_chk.sv
module alu16_ex_chk
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [4:0]   opcode,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_in,
  input logic [W-1:0] result,
  input logic [W-1:0] ex_q,
  input logic         ex_we,
  input logic         cond_true
);
  // R10
  ex_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_we |=> $stable(ex_q));

  // R10
  logic_nowe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode inside {OP_SET, OP_AND, OP_BOR, OP_XOR, OP_MOD, OP_MDI}) |-> !ex_we);

  // R2
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == OP_ADD) |=> (ex_q == W'(0) || ex_q == W'(1)));

  // R2
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == OP_SUB) |=> (ex_q == W'(0) || ex_q == {W{1'b1}}));

  // R9
  cmp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(opcode[4:3] == 2'b10) |-> !cond_true);

  // R4
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((opcode == OP_DIV || opcode == OP_DVI) && a_in == '0) |-> result == '0);
endmodule

bind alu16_ex alu16_ex_chk #(.W(W)) u_chk (.*);

// File: tb/tb_alu16_ex.sv
module tb_alu16_ex;
  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [4:0]  opcode;
  logic [15:0] b_in, a_in;
  logic [15:0] result, ex_q;
  logic        ex_we, cond_true;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] r;
    logic [15:0] nx;
    bit          we;
    bit          c;
    string       tag;
  } item_t;

  item_t sbq[$];
  logic [15:0] ex_model;

  alu16_ex dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .b_in(b_in), .a_in(a_in), .result(result), .ex_q(ex_q),
    .ex_we(ex_we), .cond_true(cond_true));

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk16(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Reference model built from the requirement text.
  task automatic model(input logic [4:0] op, input logic [15:0] b, input logic [15:0] a,
                       input logic [15:0] ex, output logic [15:0] r, output logic [15:0] nx,
                       output bit we, output bit c);
    longint ub, ua, sb, sa, t;
    ub = longint'(b); ua = longint'(a);
    sb = longint'($signed(b)); sa = longint'($signed(a));
    r = b; nx = ex; we = 0; c = 0;
    case (op)
      5'h01: r = a;
      5'h02: begin t = ub + ua; r = t[15:0]; nx = (t > 65535) ? 16'h1 : 16'h0; we = 1; end
      5'h03: begin r = b - a; nx = (ua > ub) ? 16'hffff : 16'h0; we = 1; end
      5'h04: begin t = ub * ua; r = t[15:0]; nx = t[31:16]; we = 1; end
      5'h05: begin t = sb * sa; r = t[15:0]; nx = t[31:16]; we = 1; end
      5'h06: begin
        we = 1;
        if (ua == 0) begin r = 0; nx = 0; end
        else begin t = ub / ua; r = t[15:0]; t = (ub * 65536) / ua; nx = t[15:0]; end
      end
      5'h07: begin
        we = 1;
        if (ua == 0) begin r = 0; nx = 0; end
        else begin t = sb / sa; r = t[15:0]; t = (sb * 65536) / sa; nx = t[15:0]; end
      end
      5'h08: begin if (ua == 0) r = 0; else begin t = ub % ua; r = t[15:0]; end end
      5'h09: begin if (ua == 0) r = 0; else begin t = sb % sa; r = t[15:0]; end end
      5'h0a: r = b & a;
      5'h0b: r = b | a;
      5'h0c: r = b ^ a;
      5'h0d: begin
        we = 1;
        if (ua >= 16) begin r = 0; nx = 0; end
        else begin r = b >> ua; t = (ub * 65536) >> ua; nx = t[15:0]; end
      end
      5'h0e: begin
        we = 1;
        if (ua >= 16) begin r = b[15] ? 16'hffff : 16'h0; nx = r; end
        else begin t = sb >>> ua; r = t[15:0]; t = (sb * 65536) >>> ua; nx = t[15:0]; end
      end
      5'h0f: begin
        we = 1;
        if (ua >= 16) begin r = 0; nx = 0; end
        else begin t = ub << ua; r = t[15:0]; nx = t[31:16]; end
      end
      5'h10: c = (b & a) != 0;
      5'h11: c = (b & a) == 0;
      5'h12: c = (b == a);
      5'h13: c = (b != a);
      5'h14: c = (ub > ua);
      5'h15: c = (sb > sa);
      5'h16: c = (ub < ua);
      5'h17: c = (sb < sa);
      5'h1a: begin t = ub + ua + longint'(ex); r = t[15:0]; nx = (t > 65535) ? 16'h1 : 16'h0; we = 1; end
      5'h1b: begin
        t = ub - ua + longint'(ex); r = t[15:0]; we = 1;
        if (t < 0) nx = 16'hffff; else if (t > 65535) nx = 16'h1; else nx = 16'h0;
      end
      default: ;
    endcase
  endtask

  // Driver: applies one operation for one period and queues its expectation.
  task automatic drive(input logic [4:0] op, input logic [15:0] b, input logic [15:0] a,
                       input string tag, input bit valid = 1);
    item_t it;
    @(negedge clk);
    op_valid = valid; opcode = op; b_in = b; a_in = a;
    model(op, b, a, ex_model, it.r, it.nx, it.we, it.c);
    if (!valid) begin it.we = 0; it.nx = ex_model; end
    it.tag = tag;
    ex_model = it.nx;
    sbq.push_back(it);
  endtask

  // Monitor: combinational outputs mid-low phase, register just after the edge.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        chk16(it.tag, "result", result, it.r);
        chk16(it.tag, "cond_true", {15'b0, cond_true}, {15'b0, it.c});
        chk16(it.tag, "ex_we", {15'b0, ex_we}, {15'b0, it.we});
        @(posedge clk);
        #1;
        chk16(it.tag, "ex_q", ex_q, it.nx);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_valid = 0; opcode = 5'h00; b_in = 16'h1234; a_in = 16'h0;
    ex_model = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #2;
    // R10 reset state
    chk16("R10", "reset ex_q", ex_q, 16'h0);
    chk16("R9", "idle cond_true", {15'b0, cond_true}, 16'h0);
    chk16("R1", "idle result", result, 16'h1234);

    // R1 move and logic
    drive(5'h01, 16'h1111, 16'hbeef, "R1");
    drive(5'h0a, 16'hf0f0, 16'h3c3c, "R1");
    drive(5'h0b, 16'hf0f0, 16'h3c3c, "R1");
    drive(5'h0c, 16'hf0f0, 16'h3c3c, "R1");
    // R2 add and subtract
    drive(5'h02, 16'hffff, 16'h0001, "R2");
    drive(5'h02, 16'h0001, 16'h0002, "R2");
    drive(5'h03, 16'h0000, 16'h0001, "R2");
    drive(5'h03, 16'h0005, 16'h0003, "R2");
    // R3 multiply
    drive(5'h04, 16'hffff, 16'hffff, "R3");
    drive(5'h05, 16'hffff, 16'hffff, "R3");
    drive(5'h05, 16'hfffe, 16'h0003, "R3");
    // R4 divide
    drive(5'h06, 16'h0007, 16'h0002, "R4");
    drive(5'h06, 16'h0005, 16'h0000, "R4");
    drive(5'h07, 16'hfff9, 16'h0002, "R4");
    drive(5'h07, 16'h8000, 16'hffff, "R4");
    drive(5'h07, 16'h0123, 16'h0000, "R4");
    // R5 remainder, excess untouched
    drive(5'h02, 16'hffff, 16'h0001, "R5");
    drive(5'h08, 16'h0007, 16'h0003, "R5");
    drive(5'h08, 16'h0007, 16'h0000, "R5");
    drive(5'h09, 16'hfff9, 16'h0010, "R5");
    drive(5'h09, 16'h0007, 16'hfffd, "R5");
    // R6 short shifts
    drive(5'h0d, 16'h1234, 16'h0004, "R6");
    drive(5'h0e, 16'h8001, 16'h0001, "R6");
    drive(5'h0f, 16'habcd, 16'h0004, "R6");
    drive(5'h0d, 16'h1234, 16'h0000, "R6");
    // R7 wide shifts
    drive(5'h0d, 16'hffff, 16'h0010, "R7");
    drive(5'h0f, 16'hffff, 16'h0014, "R7");
    drive(5'h0e, 16'h8000, 16'h0014, "R7");
    drive(5'h0e, 16'h7000, 16'h0010, "R7");
    drive(5'h0e, 16'h8000, 16'h8000, "R7");
    // R8 carry chains
    drive(5'h02, 16'hffff, 16'h0001, "R8");
    drive(5'h1a, 16'hffff, 16'h0000, "R8");
    drive(5'h1a, 16'h0001, 16'h0002, "R8");
    drive(5'h03, 16'h0000, 16'h0001, "R8");
    drive(5'h1b, 16'h0005, 16'h0003, "R8");
    drive(5'h1b, 16'h0000, 16'h0001, "R8");
    drive(5'h1b, 16'h0000, 16'h0005, "R8");
    // R9 compares over several operand pairs
    for (int op = 16; op < 24; op++) begin
      drive(5'(op), 16'h8000, 16'h0001, "R9");
      drive(5'(op), 16'h0005, 16'h0005, "R9");
      drive(5'(op), 16'h0003, 16'hfffe, "R9");
    end
    drive(5'h18, 16'h0005, 16'h0005, "R9");
    // R10 no commit when op_valid is low
    drive(5'h02, 16'hffff, 16'h0001, "R10", 1'b0);
    drive(5'h0f, 16'h00ff, 16'h0008, "R10", 1'b0);
    drive(5'h19, 16'h0001, 16'h0001, "R10");

    @(negedge clk);
    op_valid = 0; opcode = 5'h00;
    repeat (4) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule